// File: doc/BRIEF.md
# Snapshot Byte Reader for Two 16-bit Counters

This block lets an 8-bit register bus read two live 16-bit quantities, a running down-counter and a capture register, without tearing. Both values change independently of the bus. A read of either low byte returns that byte. On the same clock edge, the block copies the matching high byte into one shared holding register. A later read of the high-byte location returns the held copy, so the two bytes belong to the same instant. The holding register answers at two alias addresses. Because it is shared, software must fetch the high byte before it starts any other low-byte read.

Requests and responses travel on valid/ready channels. A request (`req_valid`, `req_addr`) is accepted on a rising edge where `req_valid` and `req_ready` are both high. Every side effect of a request happens only on that accepting edge. The response register presents `rsp_data` with `rsp_valid` from the next cycle. It holds that data, unchanged, until a cycle where `rsp_ready` is high. `req_ready` is high whenever the response slot is empty or is being drained in the same cycle. This makes back-pressure on the response side stall the request side with no extra storage.

Top module: `snap_reader`

## Requirements
- R1: After reset, `rsp_valid` is 0, `req_ready` is 1, and a high-byte read returns 0x00.
- R2: An accepted read of address 0 (counter low byte) returns `dec_val[7:0]` as sampled on the accepting edge. The response appears one cycle after acceptance.
- R3: The accepting edge of an address-0 read loads `dec_val[15:8]` from that same edge into the shared holding register.
- R4: An accepted read of address 2 (capture low byte) returns `cap_val[7:0]`. On the same edge it loads `cap_val[15:8]` into the shared holding register.
- R5: Reads of address 1 and address 3 both return the holding register's contents.
- R6: High-byte reads leave the holding register unchanged, so repeated high-byte reads return the same byte.
- R7: Every accepted low-byte read reloads the holding register, even when the previous high byte was never fetched.
- R8: Reads of any address other than 0–3 return 0x00 and leave the holding register unchanged.
- R9: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_data` and `rsp_valid` hold steady and `req_ready` is 0. A request offered in that time is not accepted and has no effect.
- R10: The low byte and the held high byte come from the same edge, even when the counter decrements across a byte boundary in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_val | input | 16 | Live down-counter value |
| cap_val | input | 16 | Live capture register value |
| req_valid | input | 1 | Read request offered |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_addr | input | 4 | Read address |
| rsp_valid | output | 1 | Read data available |
| rsp_ready | input | 1 | Consumer takes read data |
| rsp_data | output | 8 | Read data byte |

## Verification
Two things can fall in the same cycle: a low-byte read and a change of the counter. The bench decrements `dec_val` on every cycle of every read and starts each counter read one count above a borrow from the low byte. The reported low byte and the later high byte must then both match the value present on the accepting edge, not the value after the borrow. The second collision is a stalled response against a new request. The bench presents a capture low-byte request while the response is blocked, then confirms that the held high byte still belongs to the earlier counter read.

// File: rtl/snap_pkg.sv
package snap_pkg;
  typedef enum logic [1:0] {
    PICK_NONE = 2'd0,
    PICK_DEC  = 2'd1,
    PICK_CAP  = 2'd2,
    PICK_HOLD = 2'd3
  } pick_e;
endpackage

// File: rtl/snap_decode.sv
module snap_decode
  import snap_pkg::*;
#(
  parameter int AW = 4,
  parameter int NALIAS = 2,
  parameter logic [AW-1:0] DEC_ADDR = 4'd0,
  parameter logic [AW-1:0] CAP_ADDR = 4'd2,
  parameter logic [NALIAS-1:0][AW-1:0] HOLD_ADDRS = {4'd3, 4'd1}
) (
  input  logic [AW-1:0] addr,
  output pick_e         pick
);
  logic [NALIAS-1:0] alias_hit;

  for (genvar g = 0; g < NALIAS; g++) begin : g_alias
    assign alias_hit[g] = (addr == HOLD_ADDRS[g]);
  end

  always_comb begin
    if (addr == DEC_ADDR)      pick = PICK_DEC;
    else if (addr == CAP_ADDR) pick = PICK_CAP;
    else if (|alias_hit)       pick = PICK_HOLD;
    else                       pick = PICK_NONE;
  end
endmodule

// File: rtl/snap_hold.sv
module snap_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          from_cap,
  input  logic [DW-1:0] dec_hi,
  input  logic [DW-1:0] cap_hi,
  output logic [DW-1:0] q
);
  logic [DW-1:0] nxt;

  always_comb nxt = from_cap ? cap_hi : dec_hi;

  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= nxt;
  end

  assert_hold_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q));
endmodule

// File: rtl/snap_resp.sv
module snap_resp #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [DW-1:0] din,
  input  logic          rsp_ready,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          can_take
);
  assign can_take = !rsp_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (take) begin
      rsp_valid <= 1'b1;
      rsp_data  <= din;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
  assert_no_take_stalled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !take);
endmodule

// File: rtl/snap_reader.sv
module snap_reader
  import snap_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 4,
  localparam int VW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [VW-1:0] dec_val,
  input  logic [VW-1:0] cap_val,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_data
);
  pick_e         pick;
  logic          fire;
  logic          low_read;
  logic [DW-1:0] held;
  logic [DW-1:0] byte_out;

  snap_decode #(.AW(AW)) u_dec (
    .addr (req_addr),
    .pick (pick)
  );

  assign fire     = req_valid && req_ready;
  assign low_read = fire && (pick == PICK_DEC || pick == PICK_CAP);

  snap_hold #(.DW(DW)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (low_read),
    .from_cap (pick == PICK_CAP),
    .dec_hi   (dec_val[VW-1:DW]),
    .cap_hi   (cap_val[VW-1:DW]),
    .q        (held)
  );

  always_comb begin
    unique case (pick)
      PICK_DEC:  byte_out = dec_val[DW-1:0];
      PICK_CAP:  byte_out = cap_val[DW-1:0];
      PICK_HOLD: byte_out = held;
      default:   byte_out = '0;
    endcase
  end

  snap_resp #(.DW(DW)) u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (fire),
    .din       (byte_out),
    .rsp_ready (rsp_ready),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .can_take  (req_ready)
  );

  assert_dec_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && pick == PICK_DEC) |=> (held == $past(dec_val[VW-1:DW])
      && rsp_data == $past(dec_val[DW-1:0])));
  assert_cap_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && pick == PICK_CAP) |=> (held == $past(cap_val[VW-1:DW])
      && rsp_data == $past(cap_val[DW-1:0])));
  assert_alias_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && pick == PICK_HOLD) |=> (rsp_valid && rsp_data == $past(held)));
  assert_other_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && pick == PICK_NONE) |=> (rsp_valid && rsp_data == '0 && $stable(held)));
endmodule

// File: tb/tb_snap_reader.sv
module tb_snap_reader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] dec_val = 16'h0;
  logic [15:0] cap_val = 16'h0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_addr = 4'd0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [7:0]  rsp_data;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  snap_reader dut (
    .clk(clk), .rst_n(rst_n), .dec_val(dec_val), .cap_val(cap_val),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // one read; the counter ticks down on every cycle, snapshot taken for the accepting edge
  task automatic rd(input logic [3:0] a, output logic [7:0] d,
                    output logic [15:0] sd, output logic [15:0] sc);
    @(negedge clk);
    dec_val = dec_val - 16'd1;
    req_valid = 1'b1; req_addr = a; rsp_ready = 1'b1;
    sd = dec_val; sc = cap_val;
    @(negedge clk);
    dec_val = dec_val - 16'd1;
    req_valid = 1'b0;
    check("R2 rsp_valid", {15'd0, rsp_valid}, 16'd1);
    d = rsp_data;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0]  d;
    logic [15:0] sd, sc, sd2, sx;
    repeat (3) @(negedge clk);
    check("R1 rsp_valid", {15'd0, rsp_valid}, 16'd0);
    check("R1 req_ready", {15'd0, req_ready}, 16'd1);
    rst_n = 1'b1;
    rd(4'd1, d, sd, sc);
    check("R1 hold after reset", {8'd0, d}, 16'd0);

    for (int i = 0; i < 256; i++) begin
      cap_val = 16'(i * 257) ^ 16'h5a3c;
      // counter reaches xx00 on the accepting edge, borrows right after (R10)
      dec_val = {8'(i + 1), 8'h01};
      rd(4'd0, d, sd, sc);
      check("R2 dec low", {8'd0, d}, {8'd0, sd[7:0]});
      rd((i % 2 == 0) ? 4'd1 : 4'd3, d, sx, sx);
      check("R3 R5 R10 dec high", {8'd0, d}, {8'd0, sd[15:8]});
      rd(4'd2, d, sx, sc);
      check("R4 cap low", {8'd0, d}, {8'd0, sc[7:0]});
      rd(4'd3, d, sx, sx);
      check("R4 R5 cap high", {8'd0, d}, {8'd0, sc[15:8]});
      rd(4'd1, d, sx, sx);
      check("R6 repeat high", {8'd0, d}, {8'd0, sc[15:8]});
      if (i % 16 == 5) begin
        rd(4'd0, d, sd2, sx);
        rd(4'd2, d, sx, sc);
        rd(4'd1, d, sx, sx);
        check("R7 overwrite pending", {8'd0, d}, {8'd0, sc[15:8]});
      end
    end

    // R8: unmapped addresses
    cap_val = 16'hc3e1;
    rd(4'd2, d, sx, sc);
    for (int a = 4; a < 16; a++) begin
      rd(4'(a), d, sx, sx);
      check("R8 unmapped zero", {8'd0, d}, 16'd0);
      rd(4'd3, d, sx, sx);
      check("R8 hold untouched", {8'd0, d}, {8'd0, sc[15:8]});
    end

    // R9: back-pressure
    dec_val = 16'hb7e4;
    cap_val = 16'h1122;
    @(negedge clk);
    rsp_ready = 1'b0; req_valid = 1'b1; req_addr = 4'd0; sd = dec_val;
    @(negedge clk);
    req_addr = 4'd2;
    for (int k = 0; k < 3; k++) begin
      check("R9 valid held", {15'd0, rsp_valid}, 16'd1);
      check("R9 data held", {8'd0, rsp_data}, {8'd0, sd[7:0]});
      check("R9 ready low", {15'd0, req_ready}, 16'd0);
      @(negedge clk);
    end
    req_valid = 1'b0; rsp_ready = 1'b1;
    @(negedge clk);
    check("R9 drained", {15'd0, rsp_valid}, 16'd0);
    rd(4'd1, d, sx, sx);
    check("R9 blocked request no effect", {8'd0, d}, {8'd0, sd[15:8]});

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule